// File: doc/BRIEF.md
# Self-Framing Serial Segment Driver

This block receives a display image over a two-wire serial link, one data line and one clock line, plus an enable line that qualifies the clock. Each frame carries no length field and has no load strobe. A frame starts with a single bit of value 1, and 35 payload bits follow it. The start bit travels down a 36-stage shift chain. When it reaches the last stage, the 35 payload bits are copied into a parallel latch, and that latch drives the LED segment outputs directly.

A faster system clock oversamples all three serial inputs. The block runs the copy just after the rising serial edge that completes the frame. It clears the chain on the falling serial edge that follows, so the next start bit can arrive on the very next rising edge. A partial frame is neither copied nor cleared. Its bits stay in the chain, and the clocks that follow continue to shift them.

Top module: `segdrv_top`

## Requirements
- R1: A frame is a start bit of 1 and then 35 data bits. The output latch is loaded on the 36th qualified rising serial edge counted from the start bit, which is the edge that moves the start bit into the last chain stage.
- R2: The first data bit after the start bit appears on segOut[0], and data bit k appears on segOut[k-1]. A data bit of 1 drives its output high.
- R3: When fewer than 36 qualified edges arrive, no load happens and segOut keeps its value. The partial bits remain in the chain and continue to shift on later qualified edges.
- R4: After a load, the chain is cleared on the next falling serial edge. A start bit on the next rising edge then begins a new frame with no idle clocks in between.
- R5: A rising serial edge seen while serEn is low is ignored: nothing shifts and nothing loads.
- R6: While rstN is low, the chain, segOut and frameDone are all 0. The first start bit after reset begins a normal frame.
- R7: frameDone is a single-cycle pulse, high in the same cycle that the new segOut value first appears. This is 4 system clocks after the completing serial rising edge reaches the pins.
- R8: segOut changes only in the cycle a load lands. A repeated frame with equal payload leaves every output unchanged but still pulses frameDone.
- R9: Qualified clocks carrying 0 into an empty chain have no effect, so idle zero bits in front of a start bit do not disturb the frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 8 times the serial clock rate |
| rstN | input | 1 | Asynchronous active-low power-on reset |
| serClk | input | 1 | Serial clock, asynchronous to clk |
| serData | input | 1 | Serial data, sampled on the rising serial edge |
| serEn | input | 1 | Serial clock qualifier; rising edges count only while it is high |
| segOut | output | 35 | Latched segment drive, one bit per LED segment |
| frameDone | output | 1 | One-cycle pulse when the latch takes a new frame |

## Verification
Each serial input passes through two synchronizer flops and one edge-detect register before the chain shifts. The latch then writes one cycle after that, so segOut and frameDone are due on the 4th system edge after the completing serial rise is driven. The bench drives on falling system edges and samples frameDone at every falling edge during the high serial phase. On a load it requires frameDone low at the 3rd sample and high at the 4th, and the new segOut at the 4th. When no load is due, it requires no pulse and an unchanged segOut. The chain clear, due at the following serial fall, is checked through its effect: the next frame begins on the very next rising edge and must decode exactly. A cycle-free model of the chain inside the bench supplies the expected segOut.

// File: rtl/segdrv_pkg.sv
package segdrv_pkg;
  // strobes from control to datapath, one system cycle wide each
  typedef struct packed {
    logic sample;  // shift serial data into stage 0
    logic load;    // copy payload into output latch
    logic clear;   // zero the whole shift chain
  } segStrobe_t;
endpackage

// File: rtl/segdrv_sync.sv
module segdrv_sync #(
  parameter int W = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] pipe [STAGES];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < STAGES; i++) pipe[i] <= '0;
    end else begin
      pipe[0] <= din;
      for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
    end
  end

  assign dout = pipe[STAGES-1];
endmodule

// File: rtl/segdrv_ctrl.sv
module segdrv_ctrl
  import segdrv_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       clkS,
  input  logic       enS,
  input  logic       chainTop,
  output segStrobe_t strb
);
  logic clkPrev;
  logic clearPend;
  logic riseQ;
  logic fallS;

  assign riseQ = clkS & ~clkPrev & enS;
  assign fallS = ~clkS & clkPrev;

  always_comb begin
    strb.sample = riseQ;
    strb.load   = chainTop & ~clearPend;
    strb.clear  = clearPend & fallS;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      clkPrev   <= 1'b0;
      clearPend <= 1'b0;
    end else begin
      clkPrev <= clkS;
      if (strb.load)       clearPend <= 1'b1;
      else if (strb.clear) clearPend <= 1'b0;
    end
  end
endmodule

// File: rtl/segdrv_path.sv
module segdrv_path
  import segdrv_pkg::*;
#(
  parameter int PAYLOAD_W = 35
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  segStrobe_t           strb,
  input  logic                 dataS,
  output logic                 chainTop,
  output logic [PAYLOAD_W-1:0] segOut,
  output logic                 frameDone
);
  localparam int FRAME_W = PAYLOAD_W + 1;

  logic [FRAME_W-1:0]   chain;
  logic [PAYLOAD_W-1:0] ordered;

  // oldest payload bit sits just under the start bit
  for (genvar i = 0; i < PAYLOAD_W; i++) begin : g_order
    assign ordered[i] = chain[PAYLOAD_W-1-i];
  end

  assign chainTop = chain[FRAME_W-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      chain <= '0;
    end else if (strb.clear) begin
      chain <= '0;
    end else if (strb.sample) begin
      chain <= {chain[FRAME_W-2:0], dataS};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      segOut    <= '0;
      frameDone <= 1'b0;
    end else begin
      frameDone <= strb.load;
      if (strb.load) segOut <= ordered;
    end
  end
endmodule

// File: rtl/segdrv_top.sv
module segdrv_top
  import segdrv_pkg::*;
#(
  parameter int PAYLOAD_W = 35,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 serClk,
  input  logic                 serData,
  input  logic                 serEn,
  output logic [PAYLOAD_W-1:0] segOut,
  output logic                 frameDone
);
  logic [2:0] rawIn;
  logic [2:0] syncOut;
  logic       chainTop;
  segStrobe_t strb;

  assign rawIn = {serEn, serData, serClk};

  segdrv_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rstN(rstN),
    .din (rawIn),
    .dout(syncOut)
  );

  segdrv_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .clkS    (syncOut[0]),
    .enS     (syncOut[2]),
    .chainTop(chainTop),
    .strb    (strb)
  );

  segdrv_path #(.PAYLOAD_W(PAYLOAD_W)) u_path (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .dataS    (syncOut[1]),
    .chainTop (chainTop),
    .segOut   (segOut),
    .frameDone(frameDone)
  );
endmodule

// File: rtl/segdrv_chk.sv
module segdrv_chk
  import segdrv_pkg::*;
#(
  parameter int PAYLOAD_W = 35
) (
  input logic                 clk,
  input logic                 rstN,
  input segStrobe_t           strb,
  input logic                 chainTop,
  input logic [PAYLOAD_W-1:0] segOut,
  input logic                 frameDone
);
  // R8
  hold_outputs_chk: assert property (@(posedge clk) disable iff (!rstN)
    !frameDone |-> $stable(segOut));

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    frameDone |=> !frameDone);

  // R7
  load_lands_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.load |=> frameDone);

  // R4
  clear_empties_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.clear |=> !chainTop);

  // R4
  single_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.load |=> !strb.load);

  // R1
  no_load_on_shift_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.sample |-> !strb.load);

  // R6
  reset_state_chk: assert property (@(posedge clk)
    !rstN |=> (segOut == '0 && !frameDone));
endmodule

bind segdrv_top segdrv_chk #(.PAYLOAD_W(PAYLOAD_W)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .strb     (strb),
  .chainTop (chainTop),
  .segOut   (segOut),
  .frameDone(frameDone)
);

// File: tb/tb_segdrv_top.sv
module tb_segdrv_top;
  localparam int PW = 35;
  localparam int LOW_CYC = 6;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          serClk = 1'b0;
  logic          serData = 1'b0;
  logic          serEn = 1'b0;
  logic [PW-1:0] segOut;
  logic          frameDone;

  int    total = 0;
  int    bad = 0;
  bit    finished = 0;
  string curReq = "R1";

  logic [PW:0]   mChain = '0;
  logic [PW-1:0] mSeg = '0;

  always #4 clk = ~clk;  // 125 MHz

  segdrv_top dut (
    .clk(clk), .rstN(rstN), .serClk(serClk), .serData(serData),
    .serEn(serEn), .segOut(segOut), .frameDone(frameDone)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [PW-1:0] decode(input logic [PW:0] ch);
    logic [PW-1:0] r;
    for (int i = 0; i < PW; i++) r[i] = ch[PW-1-i];
    return r;
  endfunction

  // one serial bit: low phase then high phase, monitoring the high phase
  task automatic serBit(input logic d, input logic en);
    logic          seen [7];
    logic [PW-1:0] segAt4;
    logic [PW-1:0] segPrev;
    bit            loadNow;
    @(negedge clk);
    serClk = 1'b0; serData = d; serEn = en;
    repeat (LOW_CYC) @(negedge clk);
    segPrev = segOut;
    serClk = 1'b1;
    segAt4 = '0;
    for (int i = 1; i <= 6; i++) begin
      @(negedge clk);
      seen[i] = frameDone;
      if (i == 4) segAt4 = segOut;
    end
    serClk = 1'b0;
    loadNow = 0;
    if (en) begin
      mChain = {mChain[PW-1:0], d};
      if (mChain[PW]) begin
        loadNow = 1;
        mSeg = decode(mChain);
        mChain = '0;
      end
    end
    if (loadNow) begin
      check(seen[3] == 1'b0 && seen[4] == 1'b1, "R7 pulse timing",
            {seen[3], seen[4]}, 2'b01);
      check(segAt4 == mSeg, curReq, segAt4, mSeg);
    end else begin
      check(!(seen[1] | seen[2] | seen[3] | seen[4] | seen[5] | seen[6]),
            "R8 stray pulse", 1, 0);
      check(segOut == segPrev, curReq, segOut, segPrev);
    end
  endtask

  task automatic sendFrame(input logic [PW-1:0] pay);
    serBit(1'b1, 1'b1);
    for (int i = 0; i < PW; i++) serBit(pay[i], 1'b1);
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    mChain = '0; mSeg = '0;
    check(segOut == '0, "R6 segOut", segOut, 0);
    check(frameDone == 1'b0, "R6 frameDone", frameDone, 0);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    void'($urandom(32'h5eed_1234));
    doReset();

    curReq = "R2";
    sendFrame(35'h1);
    check(segOut == 35'h1, "R2 first bit", segOut, 35'h1);
    sendFrame(35'h4_0000_0000);
    check(segOut == 35'h4_0000_0000, "R2 last bit", segOut, 35'h4_0000_0000);

    curReq = "R1";
    sendFrame('1);
    check(segOut == '1, "R1 all ones", segOut, {PW{1'b1}});
    sendFrame(35'h5_5555_5555);
    check(segOut == 35'h5_5555_5555, "R1 alternating", segOut, 35'h5_5555_5555);

    curReq = "R4";
    sendFrame(35'h2_AAAA_AAAA);
    sendFrame(35'h1_2345_6789);
    check(segOut == 35'h1_2345_6789, "R4 back to back", segOut, 35'h1_2345_6789);

    curReq = "R8";
    sendFrame(35'h1_2345_6789);
    check(segOut == 35'h1_2345_6789, "R8 repeat frame", segOut, 35'h1_2345_6789);

    curReq = "R9";
    for (int i = 0; i < 5; i++) serBit(1'b0, 1'b1);
    sendFrame(35'h0_F0F0_F0F0);
    check(segOut == 35'h0_F0F0_F0F0, "R9 idle zeros", segOut, 35'h0_F0F0_F0F0);

    curReq = "R5";
    serBit(1'b1, 1'b1);
    for (int i = 0; i < PW; i++) begin
      if (i % 7 == 3) serBit(1'b1, 1'b0);
      serBit(i[0], 1'b1);
    end
    check(segOut == 35'h2_AAAA_AAAA, "R5 enable gaps", segOut, 35'h2_AAAA_AAAA);

    curReq = "R3";
    serBit(1'b1, 1'b1);
    for (int i = 0; i < 10; i++) serBit(1'b1, 1'b1);
    check(segOut == 35'h2_AAAA_AAAA, "R3 truncated held", segOut, 35'h2_AAAA_AAAA);
    sendFrame(35'h3_0F0F_0F0F);  // model tracks the mixed load

    curReq = "R6";
    serBit(1'b1, 1'b1);
    for (int i = 0; i < 20; i++) serBit(1'b1, 1'b1);
    doReset();
    sendFrame(35'h0_00FF_00FF);
    check(segOut == 35'h0_00FF_00FF, "R6 clean after reset", segOut, 35'h0_00FF_00FF);

    curReq = "R1";
    for (int f = 0; f < 25; f++) begin
      logic [PW-1:0] pay;
      int            len;
      pay = {$urandom, $urandom};
      len = ($urandom % 5 == 0) ? int'($urandom % PW) : PW;
      serBit(1'b1, 1'b1);
      for (int i = 0; i < len; i++) begin
        if ($urandom % 10 == 0) serBit($urandom % 2, 1'b0);
        serBit(pay[i], 1'b1);
      end
    end
    repeat (10) @(negedge clk);
    check(segOut == mSeg, "R1 final state", segOut, mSeg);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule